// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a single memory access may go ahead once its page has been translated. The translation logic supplies the effective permission bits of the page: present, user-accessible, writable and no-execute. The core supplies the current privilege mode, the kind of access, and a small set of control flags. Three flags govern how supervisor code is held back from user pages and whether writes to read-only pages are enforced in kernel mode. A fourth flag lets supervisor code lift the data-access restriction for a short window.

Each request arrives with a valid strobe. Exactly one cycle later the block returns a registered response. The response holds a fault flag and a 7-bit error code. The code tells an absent page apart from a present page whose permissions were broken, and it records the access direction, the mode and the access kind. Three further violation flags come from neighbouring logic: reserved-bit, protection-key and shadow-stack. The checker folds them into the code and into the fault decision without computing them itself. A new request can be accepted on every cycle, and there is no stall path.

Top module: `pg_perm_chk`

## Requirements
- R1: Every cycle with `req_valid_i` high produces `resp_valid_o` high on the following cycle, carrying that request's result. `resp_valid_o` is low in every other cycle, and back-to-back requests are accepted without gaps.
- R2: An access to a page with `pte_present_i` = 0 faults, with error code bit 0 cleared, whatever the other page permission bits are.
- R3: A read (`acc_type_i` = 2'b00) is never refused because `pte_writable_i` is 0.
- R4: A user-mode access (`user_mode_i` = 1) of any kind to a page with `pte_user_i` = 0 faults.
- R5: An instruction fetch (`acc_type_i` = 2'b10) from a page with `pte_noexec_i` = 1 faults in both modes.
- R6: A write (`acc_type_i` = 2'b01) to a page with `pte_writable_i` = 0 always faults in user mode. In kernel mode it faults only when `kern_wp_en_i` = 1.
- R7: With `sup_exec_block_i` = 1, a kernel-mode fetch from a page with `pte_user_i` = 1 faults.
- R8: With `sup_data_block_i` = 1, a kernel-mode read or write to a page with `pte_user_i` = 1 faults when `sup_data_ovr_i` = 0, and is not refused on that ground when `sup_data_ovr_i` = 1.
- R9: With both supervisor restrictions off, kernel-mode reads, writes and fetches to user pages are subject only to the write-protect and no-execute rules.
- R10: On a fault the error code holds the following bits: bit0 = page present, bit1 = access is a write, bit2 = user mode, bit3 = `rsvd_viol_i`, bit4 = instruction fetch, bit5 = `pkey_viol_i`, bit6 = `sstk_viol_i`. Any of the three violation inputs set also forces a fault. `acc_type_i` = 2'b11 behaves as a read.
- R11: When the response reports no fault, and in every cycle without a response (including reset), `fault_o` is 0 and `err_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| pte_present_i | input | 1 | Page is mapped |
| pte_user_i | input | 1 | Page is reachable from user mode |
| pte_writable_i | input | 1 | Page accepts writes |
| pte_noexec_i | input | 1 | Fetches from the page are forbidden |
| user_mode_i | input | 1 | Access issued in user mode (0 = kernel) |
| acc_type_i | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| kern_wp_en_i | input | 1 | Enforce read-only pages on kernel writes |
| sup_exec_block_i | input | 1 | Block kernel fetches from user pages |
| sup_data_block_i | input | 1 | Block kernel data access to user pages |
| sup_data_ovr_i | input | 1 | Temporarily lift the kernel data block |
| rsvd_viol_i | input | 1 | Reserved-bit violation detected upstream |
| pkey_viol_i | input | 1 | Protection-key violation detected upstream |
| sstk_viol_i | input | 1 | Shadow-stack violation detected upstream |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| fault_o | output | 1 | Access refused |
| err_code_o | output | 7 | Fault error code, zero when no fault |

## Verification
Some rules are checked by assertions on every cycle: the one-cycle response timing, quiet outputs between responses, the cleared present bit for absent pages, no-execute and user-to-supervisor faults, and the rule that read-only never blocks a read. The interplay of write protection, the two supervisor restrictions and the override flag needs a reference model, so only the bench's exhaustive sweep over every permission, mode, access and control combination shows it. The same holds for the exact packing of all seven error bits. Directed vectors with idle gaps show that responses line up under both back-to-back and sparse traffic.

// File: rtl/pg_perm_pkg.sv
package pg_perm_pkg;

  localparam int unsigned ERR_W = 7;

  localparam int unsigned EB_PRESENT = 0;
  localparam int unsigned EB_WRITE   = 1;
  localparam int unsigned EB_USER    = 2;
  localparam int unsigned EB_RSVD    = 3;
  localparam int unsigned EB_FETCH   = 4;
  localparam int unsigned EB_PKEY    = 5;
  localparam int unsigned EB_SSTK    = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  typedef struct packed {
    logic present;
    logic user;
    logic writable;
    logic noexec;
  } pte_perm_t;

  typedef struct packed {
    logic wp_en;
    logic sup_exec_block;
    logic sup_data_block;
    logic sup_data_ovr;
  } perm_ctl_t;

  typedef struct packed {
    logic rsvd;
    logic pkey;
    logic sstk;
  } ext_viol_t;

endpackage

// File: rtl/pg_rule_eval.sv
module pg_rule_eval
  import pg_perm_pkg::*;
(
  input  pte_perm_t perm_i,
  input  perm_ctl_t ctl_i,
  input  logic      user_mode_i,
  input  acc_e      acc_i,
  output logic      is_write_o,
  output logic      is_fetch_o,
  output logic      perm_fault_o
);

  logic priv_f, wr_f, nx_f, sexec_f, sdata_f, kern_on_user;

  always_comb begin
    is_write_o   = (acc_i == ACC_WRITE);
    is_fetch_o   = (acc_i == ACC_FETCH);
    kern_on_user = !user_mode_i && perm_i.user;

    priv_f  = user_mode_i && !perm_i.user;
    nx_f    = is_fetch_o && perm_i.noexec;
    // kernel writes honour read-only only when enforcement is on
    wr_f    = is_write_o && !perm_i.writable && (user_mode_i || ctl_i.wp_en);
    sexec_f = kern_on_user && is_fetch_o && ctl_i.sup_exec_block;
    sdata_f = kern_on_user && !is_fetch_o && ctl_i.sup_data_block && !ctl_i.sup_data_ovr;

    perm_fault_o = perm_i.present && (priv_f || nx_f || wr_f || sexec_f || sdata_f);
  end

endmodule

// File: rtl/pg_err_pack.sv
module pg_err_pack
  import pg_perm_pkg::*;
(
  input  logic             fault_i,
  input  logic             present_i,
  input  logic             is_write_i,
  input  logic             is_fetch_i,
  input  logic             user_mode_i,
  input  ext_viol_t        viol_i,
  output logic [ERR_W-1:0] err_o
);

  always_comb begin
    err_o = '0;
    if (fault_i) begin
      err_o[EB_PRESENT] = present_i;
      err_o[EB_WRITE]   = is_write_i;
      err_o[EB_USER]    = user_mode_i;
      err_o[EB_RSVD]    = viol_i.rsvd;
      err_o[EB_FETCH]   = is_fetch_i;
      err_o[EB_PKEY]    = viol_i.pkey;
      err_o[EB_SSTK]    = viol_i.sstk;
    end
  end

endmodule

// File: rtl/pg_perm_chk.sv
module pg_perm_chk
  import pg_perm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             pte_present_i,
  input  logic             pte_user_i,
  input  logic             pte_writable_i,
  input  logic             pte_noexec_i,
  input  logic             user_mode_i,
  input  logic [1:0]       acc_type_i,
  input  logic             kern_wp_en_i,
  input  logic             sup_exec_block_i,
  input  logic             sup_data_block_i,
  input  logic             sup_data_ovr_i,
  input  logic             rsvd_viol_i,
  input  logic             pkey_viol_i,
  input  logic             sstk_viol_i,
  output logic             resp_valid_o,
  output logic             fault_o,
  output logic [ERR_W-1:0] err_code_o
);

  pte_perm_t        perm;
  perm_ctl_t        ctl;
  ext_viol_t        viol;
  acc_e             acc;
  logic             is_write, is_fetch, perm_fault, fault_d;
  logic [ERR_W-1:0] err_d;

  assign perm = '{present: pte_present_i, user: pte_user_i,
                  writable: pte_writable_i, noexec: pte_noexec_i};
  assign ctl  = '{wp_en: kern_wp_en_i, sup_exec_block: sup_exec_block_i,
                  sup_data_block: sup_data_block_i, sup_data_ovr: sup_data_ovr_i};
  assign viol = '{rsvd: rsvd_viol_i, pkey: pkey_viol_i, sstk: sstk_viol_i};
  assign acc  = acc_e'(acc_type_i);

  pg_rule_eval u_rules (
    .perm_i      (perm),
    .ctl_i       (ctl),
    .user_mode_i (user_mode_i),
    .acc_i       (acc),
    .is_write_o  (is_write),
    .is_fetch_o  (is_fetch),
    .perm_fault_o(perm_fault)
  );

  assign fault_d = !pte_present_i || perm_fault || (|viol);

  pg_err_pack u_pack (
    .fault_i    (fault_d),
    .present_i  (pte_present_i),
    .is_write_i (is_write),
    .is_fetch_i (is_fetch),
    .user_mode_i(user_mode_i),
    .viol_i     (viol),
    .err_o      (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      fault_o      <= 1'b0;
      err_code_o   <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      fault_o      <= req_valid_i && fault_d;
      err_code_o   <= req_valid_i ? err_d : '0;
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o) else $error("resp latency"); // R1

  AST_RESP_ONLY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o) else $error("spurious resp"); // R1

  AST_ABSENT_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !pte_present_i) |=> (fault_o && !err_code_o[EB_PRESENT]))
    else $error("absent page code"); // R2

  AST_RO_READ_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && pte_present_i && acc_type_i == 2'b00 && pte_user_i &&
     !(|viol) && (user_mode_i || !sup_data_block_i)) |=> !fault_o)
    else $error("read refused"); // R3

  AST_USER_TO_SUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && pte_present_i && user_mode_i && !pte_user_i) |=>
    (fault_o && err_code_o[EB_PRESENT] && err_code_o[EB_USER]))
    else $error("user to supervisor page"); // R4

  AST_NOEXEC_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && pte_present_i && acc_type_i == 2'b10 && pte_noexec_i) |=>
    (fault_o && err_code_o[EB_FETCH]))
    else $error("noexec fetch"); // R5

  AST_QUIET_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (err_code_o == '0)) else $error("code without fault"); // R11

endmodule

// File: tb/tb_pg_perm_chk.sv
module tb_pg_perm_chk;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 50000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       pte_present_i = 1'b0, pte_user_i = 1'b0, pte_writable_i = 1'b0, pte_noexec_i = 1'b0;
  logic       user_mode_i = 1'b0;
  logic [1:0] acc_type_i = 2'b00;
  logic       kern_wp_en_i = 1'b0, sup_exec_block_i = 1'b0, sup_data_block_i = 1'b0, sup_data_ovr_i = 1'b0;
  logic       rsvd_viol_i = 1'b0, pkey_viol_i = 1'b0, sstk_viol_i = 1'b0;
  logic       resp_valid_o, fault_o;
  logic [6:0] err_code_o;

  pg_perm_chk dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic       fault;
    logic [6:0] err;
    int         stamp;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   done  = 0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG_CYC && !done) begin
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // vec: 13 p,12 u,11 w,10 nx,9 um,8:7 acc,6 wp,5 sexec,4 sdata,3 ovr,2 rsvd,1 pkey,0 sstk
  function automatic exp_t model(input logic [13:0] v);
    exp_t e;
    logic p, u, w, nx, um, wp, se, sd, ov, rs, pk, ss, rd, wr, fe, f;
    {p, u, w, nx, um} = v[13:9];
    {wp, se, sd, ov, rs, pk, ss} = v[6:0];
    wr = (v[8:7] == 2'b01);
    fe = (v[8:7] == 2'b10);
    rd = !wr && !fe;
    f  = rs | pk | ss;
    if (!p) f = 1'b1;                                  // R2
    else begin
      if (um && !u) f = 1'b1;                          // R4
      if (fe && nx) f = 1'b1;                          // R5
      if (wr && !w) begin                              // R6
        if (um) f = 1'b1;
        else if (wp) f = 1'b1;
      end
      if (!um && u) begin
        if (fe && se) f = 1'b1;                        // R7
        if ((rd || wr) && sd && !ov) f = 1'b1;         // R8
      end
    end
    e.fault = f;
    e.err   = f ? {ss, pk, fe, rs, um, wr, p} : 7'd0;  // R10, R11
    e.stamp = 0;
    e.tag   = "";
    return e;
  endfunction

  task automatic send(input logic [13:0] v, input string tag);
    exp_t e;
    @(negedge clk_i);
    {pte_present_i, pte_user_i, pte_writable_i, pte_noexec_i, user_mode_i} = v[13:9];
    acc_type_i = v[8:7];
    {kern_wp_en_i, sup_exec_block_i, sup_data_block_i, sup_data_ovr_i,
     rsvd_viol_i, pkey_viol_i, sstk_viol_i} = v[6:0];
    req_valid_i = 1'b1;
    e = model(v);
    e.stamp = cyc;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (resp_valid_o) begin
        n_chk++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL R1: act=resp_valid exp=no response pending");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (fault_o !== e.fault || err_code_o !== e.err) begin
            n_bad++;
            $display("FAIL %s: act fault=%0b err=%07b exp fault=%0b err=%07b",
                     e.tag, fault_o, err_code_o, e.fault, e.err);
          end
        end
      end else begin
        n_chk++;
        if (fault_o !== 1'b0 || err_code_o !== 7'd0) begin
          n_bad++;
          $display("FAIL R11: idle act fault=%0b err=%07b exp fault=0 err=0000000",
                   fault_o, err_code_o);
        end
        if (q.size() > 0 && q[0].stamp < cyc) begin
          n_bad++;
          $display("FAIL R1: act=no resp exp=resp for %s", q[0].tag);
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (resp_valid_o !== 1'b0 || fault_o !== 1'b0 || err_code_o !== 7'd0) begin
      n_bad++;
      $display("FAIL R11: reset act v=%0b f=%0b e=%07b exp 0 0 0000000",
               resp_valid_o, fault_o, err_code_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // directed, with gaps
    send(14'b0_1_1_0_1_00_0000000, "R2"); idle(1);          // absent, user read
    send(14'b0_0_0_1_0_10_0000000, "R2"); idle(2);          // absent, kernel fetch
    send(14'b1_1_0_0_1_00_0000000, "R3"); idle(1);          // user read of RO page
    send(14'b1_0_0_0_0_11_1000000, "R3");                   // kernel alt-read of RO page
    send(14'b1_0_1_0_1_00_0000000, "R4");                   // user read of sup page
    send(14'b1_0_1_0_1_10_0000000, "R4"); idle(1);          // user fetch of sup page
    send(14'b1_1_1_1_1_10_0000000, "R5");                   // user fetch NX
    send(14'b1_0_1_1_0_10_0000000, "R5"); idle(1);          // kernel fetch NX
    send(14'b1_1_0_0_1_01_0000000, "R6");                   // user write RO
    send(14'b1_0_0_0_0_01_0000000, "R6");                   // kernel write RO, wp off
    send(14'b1_0_0_0_0_01_1000000, "R6"); idle(1);          // kernel write RO, wp on
    send(14'b1_1_1_0_0_10_0100000, "R7");                   // kernel fetch user page, block on
    send(14'b1_1_1_0_0_10_0000000, "R7"); idle(1);          // block off
    send(14'b1_1_1_0_0_00_0010000, "R8");                   // kernel read user, block, no ovr
    send(14'b1_1_1_0_0_01_0011000, "R8");                   // kernel write user, ovr
    send(14'b1_1_1_0_0_01_0010000, "R8"); idle(1);          // kernel write user, no ovr
    send(14'b1_1_1_0_0_01_0000000, "R9");                   // restrictions off
    send(14'b1_1_0_0_0_01_1000000, "R9");                   // still write-protected
    send(14'b1_1_1_1_0_10_0000000, "R9"); idle(1);          // still NX
    send(14'b1_1_1_0_1_00_0000100, "R10");                  // rsvd flag
    send(14'b1_1_1_0_1_01_0000010, "R10");                  // pkey flag
    send(14'b1_1_1_0_1_10_0000001, "R10");                  // sstk flag
    send(14'b0_1_1_0_1_01_0000111, "R10"); idle(2);         // absent plus all flags
    send(14'b1_1_1_0_1_01_0000000, "R11"); idle(2);         // allowed: code zero

    // exhaustive sweep, back to back
    for (int i = 0; i < 2048; i++) send({i[10:0], 3'b000}, "R10");
    idle(3);

    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: act=%0d pending exp=0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule